// File: doc/BRIEF.md
# Timer Compare Unit

This block is a 16-bit up-counter with two compare channels, A and B. The counter advances once per prescaler pulse (one pulse every `PRE_DIV` clocks). It runs in one of two modes. In free-running mode it wraps from all-ones to zero. In clear-on-match mode it returns to zero after reaching the value held in channel A's compare register. A host programs the block through a single write strobe with a 3-bit address and a data word. The writable registers are a control word, two compare values, the counter itself, two direction bits and a flag-clear word.

Each channel drives a waveform bit. A 2-bit action field chooses what happens to that bit on a compare match: nothing, toggle, force low or force high. When a channel's action field is non-zero, the channel claims its pin through an override output. The pin's driver is enabled only while the matching direction bit is also set. The compare registers can optionally be double-buffered. In that case a written value waits in a shadow register and becomes active when the counter passes TOP. The block raises sticky flags for overflow and for each channel's match, and the host clears each flag by writing a one to it.

Top module: `tmr_compare_unit`

## Requirements
- R1: While reset is held and right after it is released, the counter, the waveform bits, all flags, the override bits and the drive-enable bits are all 0.
- R2: The counter changes only on a prescaler pulse (one every `PRE_DIV` clocks) or on a counter write. On a pulse it increases by one unless it sits at TOP.
- R3: Control bit 0 selects clear-on-match mode, where TOP is channel A's active compare value and the counter goes from TOP to 0. When control bit 0 is 0, TOP is 0xFFFF and the counter wraps to 0.
- R4: Channel A's action field is control bits 7:6 and channel B's is bits 5:4. On a match the waveform bit toggles for 01, goes to 0 for 10, goes to 1 for 11, and does not change for 00.
- R5: A channel's match flag is set on a prescaler pulse where the counter equals that channel's active compare value. Writing address 5 clears the overflow flag with bit 0, channel A's flag with bit 1 and channel B's flag with bit 2. If a flag is set and cleared in the same cycle, the set wins.
- R6: A channel's override output is 1 exactly when its action field is non-zero. Its drive-enable output is the override ANDed with the channel's direction bit, which is written at address 4 (bit 0 for A, bit 1 for B).
- R7: A write to address 3 loads the counter on the next clock edge and takes priority over a pulse in the same cycle. No compare match (no flag, no waveform action) occurs on the pulse that coincides with the write, nor on the next pulse.
- R8: The overflow flag is set on a prescaler pulse where the counter is at TOP and is not being written.
- R9: Control bit 1 enables buffering. With buffering on, writes to address 1 (A) and address 2 (B) go to a shadow register, which becomes active on the pulse that takes the counter off TOP. With buffering off, a compare write becomes active on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1 compare A, 2 compare B, 3 counter, 4 direction, 5 flag clear |
| wr_data | input | W | Write data |
| cnt_o | output | W | Current counter value |
| oc_o | output | 2 | Waveform bits (bit 0 = A, bit 1 = B) |
| pin_ovr_o | output | 2 | Pin takeover per channel |
| pin_drv_o | output | 2 | Pin driver enable per channel |
| cmp_flag_o | output | 2 | Sticky match flags |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can land in the same cycle. The first is a flag clear write arriving on the same pulse that sets the flag. The bench provokes this by writing the clear word on every cycle while a short clear-on-match period keeps producing matches. The second is a counter write landing on a prescaler pulse. The bench provokes this by repeating the write at every prescaler phase. A cycle-level model built from the requirements judges both cases: the flag must stay set, the loaded value must win over the increment, and no match action may appear on the blocked pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMP0  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_DIR   = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd5;

    typedef enum logic [1:0] {
        OC_NONE   = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_CLEAR  = 2'b10,
        OC_SET    = 2'b11
    } oc_act_e;

    typedef struct packed {
        oc_act_e mode_a;
        oc_act_e mode_b;
        logic    buffered;
        logic    ctc;
    } ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick_o = (pre_q == LAST);
        pre_d  = tick_o ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2
    tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (pre_q == '0));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic                         ctc_i,
    input  logic [NUM_CH-1:0][W-1:0]     cmp_act_i,
    input  logic                         cnt_wr_i,
    input  logic [W-1:0]                 wdata_i,
    input  logic                         ovf_clr_i,
    output logic [W-1:0]                 cnt_o,
    output logic [NUM_CH-1:0]            hit_o,
    output logic                         reload_o,
    output logic                         ovf_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         blocked;
        logic         ovf;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic [W-1:0] top_val;
    logic         at_top;
    logic         match_en;

    always_comb begin
        s_d      = s_q;
        top_val  = ctc_i ? cmp_act_i[0] : {W{1'b1}};
        at_top   = (s_q.cnt == top_val);
        match_en = tick_i && !cnt_wr_i && !s_q.blocked;
        reload_o = tick_i && !cnt_wr_i && at_top;
        for (int i = 0; i < NUM_CH; i++) begin
            hit_o[i] = match_en && (s_q.cnt == cmp_act_i[i]);
        end

        if (cnt_wr_i) begin
            s_d.cnt     = wdata_i;
            s_d.blocked = 1'b1;
        end else if (tick_i) begin
            s_d.cnt     = at_top ? '0 : s_q.cnt + 1'b1;
            s_d.blocked = 1'b0;
        end

        if (ovf_clr_i) s_d.ovf = 1'b0;
        if (reload_o)  s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign ovf_o = s_q.ovf;

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr_i) |=> $stable(s_q.cnt));

    // R3
    ctc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && ctc_i && s_q.cnt == cmp_act_i[0]) |=> (s_q.cnt == '0));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> s_q.ovf);

    // R7
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (hit_o == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  oc_act_e      mode_i,
    input  logic         buffered_i,
    input  logic         hit_i,
    input  logic         reload_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         flag_clr_i,
    input  logic         dir_i,
    output logic [W-1:0] cmp_act_o,
    output logic         oc_o,
    output logic         flag_o,
    output logic         ovr_o,
    output logic         drv_o
);
    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] shadow;
        logic         oc;
        logic         flag;
    } ch_state_t;

    ch_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hit_i) begin
            unique case (mode_i)
                OC_TOGGLE: s_d.oc = ~s_q.oc;
                OC_CLEAR:  s_d.oc = 1'b0;
                OC_SET:    s_d.oc = 1'b1;
                default:   s_d.oc = s_q.oc;
            endcase
        end
        if (buffered_i && reload_i) s_d.act = s_q.shadow;
        if (cmp_wr_i) begin
            s_d.shadow = wdata_i;
            if (!buffered_i) s_d.act = wdata_i;
        end
        if (flag_clr_i) s_d.flag = 1'b0;
        if (hit_i)      s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp_act_o = s_q.act;
    assign oc_o      = s_q.oc;
    assign flag_o    = s_q.flag;
    assign ovr_o     = (mode_i != OC_NONE);
    assign drv_o     = ovr_o && dir_i;

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> s_q.flag);

    // R4
    clear_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && mode_i == OC_CLEAR) |=> !s_q.oc);

    // R4
    set_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && mode_i == OC_SET) |=> s_q.oc);

    // R4
    toggle_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && mode_i == OC_TOGGLE) |=> (s_q.oc != $past(s_q.oc)));

    // R7
    no_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(s_q.oc));

    // R9
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered_i && !reload_i && !cmp_wr_i) |=> $stable(s_q.act));

endmodule

// File: rtl/tmr_compare_unit.sv
module tmr_compare_unit
    import tmr_pkg::*;
#(
    parameter int W       = 16,
    parameter int PRE_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      cnt_o,
    output logic [NUM_CH-1:0] oc_o,
    output logic [NUM_CH-1:0] pin_ovr_o,
    output logic [NUM_CH-1:0] pin_drv_o,
    output logic [NUM_CH-1:0] cmp_flag_o,
    output logic              ovf_flag_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [NUM_CH-1:0] dir;
    } top_state_t;

    top_state_t t_d, t_q;

    logic                     tick;
    logic                     cnt_wr;
    logic                     flag_wr;
    logic [NUM_CH-1:0]        hit;
    logic                     reload;
    logic [NUM_CH-1:0]        cmp_wr;
    logic [NUM_CH-1:0]        flag_clr;
    logic [NUM_CH-1:0][W-1:0] cmp_act;
    oc_act_e                  mode_sel [NUM_CH];

    always_comb begin
        t_d = t_q;
        if (wr_en && wr_addr == ADDR_CTRL) begin
            t_d.ctrl.mode_a   = oc_act_e'(wr_data[7:6]);
            t_d.ctrl.mode_b   = oc_act_e'(wr_data[5:4]);
            t_d.ctrl.buffered = wr_data[1];
            t_d.ctrl.ctc      = wr_data[0];
        end
        if (wr_en && wr_addr == ADDR_DIR) t_d.dir = wr_data[NUM_CH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cnt_wr      = wr_en && (wr_addr == ADDR_COUNT);
    assign flag_wr     = wr_en && (wr_addr == ADDR_FLAGS);
    assign mode_sel[0] = t_q.ctrl.mode_a;
    assign mode_sel[1] = t_q.ctrl.mode_b;

    tmr_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .ctc_i     (t_q.ctrl.ctc),
        .cmp_act_i (cmp_act),
        .cnt_wr_i  (cnt_wr),
        .wdata_i   (wr_data),
        .ovf_clr_i (flag_wr && wr_data[0]),
        .cnt_o     (cnt_o),
        .hit_o     (hit),
        .reload_o  (reload),
        .ovf_o     (ovf_flag_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign cmp_wr[g]   = wr_en && (wr_addr == ADDR_CMP0 + ADDR_W'(g));
        assign flag_clr[g] = flag_wr && wr_data[g+1];

        tmr_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (mode_sel[g]),
            .buffered_i (t_q.ctrl.buffered),
            .hit_i      (hit[g]),
            .reload_i   (reload),
            .cmp_wr_i   (cmp_wr[g]),
            .wdata_i    (wr_data),
            .flag_clr_i (flag_clr[g]),
            .dir_i      (t_q.dir[g]),
            .cmp_act_o  (cmp_act[g]),
            .oc_o       (oc_o[g]),
            .flag_o     (cmp_flag_o[g]),
            .ovr_o      (pin_ovr_o[g]),
            .drv_o      (pin_drv_o[g])
        );
    end

    // R7
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_COUNT) |=> (cnt_o == $past(wr_data)));

endmodule

// File: tb/tmr_compare_unit_tb_top.sv
module tmr_compare_unit_tb_top;
    import tmr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_DIV    = 2;
    localparam int W          = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  cnt_o;
    logic [1:0]    oc_o, pin_ovr_o, pin_drv_o, cmp_flag_o;
    logic          ovf_flag_o;

    int checks = 0;
    int errors = 0;
    logic chk_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_compare_unit #(.W(W), .PRE_DIV(PRE_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .oc_o(oc_o), .pin_ovr_o(pin_ovr_o), .pin_drv_o(pin_drv_o),
        .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle model written from the requirements
    int           m_pre = 0;
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_act [2];
    logic [W-1:0] m_buf [2];
    logic         m_blk = 1'b0, m_ovf = 1'b0;
    logic [1:0]   m_oc = '0, m_flag = '0, m_dir = '0;
    logic [7:0]   m_ctrl = '0;
    logic         t_tick, t_cw, t_top_hit, t_ld;
    logic [W-1:0] t_top;
    logic [1:0]   t_hit, t_mode;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = '0; m_blk = 1'b0; m_ovf = 1'b0;
            m_oc = '0; m_flag = '0; m_dir = '0; m_ctrl = '0;
            for (int i = 0; i < 2; i++) begin m_act[i] = '0; m_buf[i] = '0; end
        end else begin
            t_tick    = (m_pre == PRE_DIV - 1);
            m_pre     = t_tick ? 0 : m_pre + 1;
            t_cw      = wr_en && wr_addr == 3'd3;
            t_top     = m_ctrl[0] ? m_act[0] : 16'hFFFF;
            t_top_hit = (m_cnt == t_top);
            t_ld      = t_tick && !t_cw && t_top_hit;
            for (int i = 0; i < 2; i++)
                t_hit[i] = t_tick && !t_cw && !m_blk && (m_cnt == m_act[i]);
            for (int i = 0; i < 2; i++) begin
                t_mode = (i == 0) ? m_ctrl[7:6] : m_ctrl[5:4];
                if (t_hit[i]) begin
                    if (t_mode == 2'b01) m_oc[i] = ~m_oc[i];
                    else if (t_mode == 2'b10) m_oc[i] = 1'b0;
                    else if (t_mode == 2'b11) m_oc[i] = 1'b1;
                end
                if (wr_en && wr_addr == 3'd5 && wr_data[i+1]) m_flag[i] = 1'b0;
                if (t_hit[i]) m_flag[i] = 1'b1;
                if (t_ld && m_ctrl[1]) m_act[i] = m_buf[i];
                if (wr_en && wr_addr == 3'(i + 1)) begin
                    m_buf[i] = wr_data;
                    if (!m_ctrl[1]) m_act[i] = wr_data;
                end
            end
            if (wr_en && wr_addr == 3'd5 && wr_data[0]) m_ovf = 1'b0;
            if (t_ld) m_ovf = 1'b1;
            if (t_cw) begin m_cnt = wr_data; m_blk = 1'b1; end
            else if (t_tick) begin m_cnt = t_top_hit ? '0 : m_cnt + 1'b1; m_blk = 1'b0; end
            if (wr_en && wr_addr == 3'd0) m_ctrl = {wr_data[7:4], 2'b00, wr_data[1:0]};
            if (wr_en && wr_addr == 3'd4) m_dir = wr_data[1:0];
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2", "counter", 32'(cnt_o), 32'(m_cnt));
            chk("R8", "overflow flag", 32'(ovf_flag_o), 32'(m_ovf));
            chk("R5", "match flags", 32'(cmp_flag_o), 32'(m_flag));
            chk("R4", "waveform bits", 32'(oc_o), 32'(m_oc));
            chk("R6", "override", 32'(pin_ovr_o), 32'({m_ctrl[5:4] != 2'b00, m_ctrl[7:6] != 2'b00}));
            chk("R6", "drive enable", 32'(pin_drv_o),
                32'({m_ctrl[5:4] != 2'b00, m_ctrl[7:6] != 2'b00} & m_dir));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period_max(output int mx);
        logic [W-1:0] prev;
        mx = int'(cnt_o);
        prev = cnt_o;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            if (prev != 0 && cnt_o == 0) break;
            prev = cnt_o;
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        int mx;
        logic oc_before;
        idle(3);
        // R1: state under reset
        chk("R1", "counter in reset", 32'(cnt_o), 0);
        chk("R1", "waveform in reset", 32'(oc_o), 0);
        chk("R1", "flags in reset", 32'({cmp_flag_o, ovf_flag_o}), 0);
        chk("R1", "pins in reset", 32'({pin_ovr_o, pin_drv_o}), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        idle(1);
        chk("R1", "counter after reset", 32'(cnt_o), 0);

        // R6: override and drive-enable combinations
        wr(3'd0, 16'h0080); wr(3'd4, 16'h0003); idle(1);
        chk("R6", "override A only", 32'(pin_ovr_o), 32'h1);
        chk("R6", "drive A only", 32'(pin_drv_o), 32'h1);
        wr(3'd0, 16'h00D0); wr(3'd4, 16'h0002); idle(1);
        chk("R6", "override both", 32'(pin_ovr_o), 32'h3);
        chk("R6", "drive B only", 32'(pin_drv_o), 32'h2);

        // Free-running with both channels active
        wr(3'd1, 16'd5); wr(3'd2, 16'd9); wr(3'd0, 16'h0070); idle(60);

        // R3 / R4: sweep of action pairs and TOP values in clear-on-match mode
        for (int ma = 0; ma < 4; ma++)
            for (int mb = 0; mb < 4; mb++)
                for (int tp = 2; tp <= 5; tp += 3) begin
                    wr(3'd0, 16'((ma << 6) | (mb << 4) | 1));
                    wr(3'd4, 16'((ma + mb) & 3));
                    wr(3'd1, 16'(tp));
                    wr(3'd2, 16'(tp - 1));
                    wr(3'd3, 16'd0);
                    period_max(mx);
                    chk("R3", "clear-on-match period peak", 32'(mx), 32'(tp));
                    period_max(mx);
                    wr(3'd5, 16'h0007);
                end

        // R4: directed set then clear on channel A
        wr(3'd0, 16'h00C1); wr(3'd1, 16'd3); wr(3'd3, 16'd0); idle(12);
        chk("R4", "set action drives A high", 32'(oc_o[0]), 1);
        wr(3'd0, 16'h0081); idle(12);
        chk("R4", "clear action drives A low", 32'(oc_o[0]), 0);

        // R7: counter writes at every prescaler phase
        wr(3'd0, 16'h0011); wr(3'd1, 16'd30); wr(3'd2, 16'd10);
        for (int k = 0; k < 6; k++) begin
            wr(3'd3, 16'd10);
            idle(k);
        end
        // R7: directed blocked match
        wr(3'd3, 16'd0); wr(3'd5, 16'h0007);
        oc_before = oc_o[1];
        wr(3'd3, 16'd10);
        idle(3 * PRE_DIV);
        chk("R7", "counter moved past written value", 32'(cnt_o > 16'd10 && cnt_o < 16'd14), 1);
        chk("R7", "no match flag after write", 32'(cmp_flag_o[1]), 0);
        chk("R7", "no waveform action after write", 32'(oc_o[1]), 32'(oc_before));

        // R8 / R3: free-running wrap
        wr(3'd0, 16'h0000); wr(3'd5, 16'h0007); wr(3'd3, 16'hFFFE);
        idle(4 * PRE_DIV);
        chk("R3", "free-running wrap", 32'(cnt_o < 16'd8), 1);
        chk("R8", "overflow flag on wrap", 32'(ovf_flag_o), 1);

        // R5: clear on every cycle while matches keep firing
        wr(3'd0, 16'h0051); wr(3'd1, 16'd3); wr(3'd2, 16'd1); wr(3'd3, 16'd0);
        for (int k = 0; k < 40; k++) wr(3'd5, 16'h0007);
        wr(3'd5, 16'h0007); idle(1);
        wr(3'd3, 16'd0); wr(3'd5, 16'h0007); idle(1);
        chk("R5", "flags cleared by write", 32'(cmp_flag_o), 0);

        // R9: buffered compare reload at TOP
        wr(3'd0, 16'h0001); wr(3'd1, 16'd8); wr(3'd0, 16'h0003);
        wr(3'd3, 16'd0); wr(3'd1, 16'd4);
        period_max(mx);
        chk("R9", "old TOP holds until reload", 32'(mx), 8);
        period_max(mx);
        chk("R9", "new TOP after reload", 32'(mx), 4);
        wr(3'd0, 16'h0001); wr(3'd1, 16'd6); wr(3'd3, 16'd0);
        period_max(mx);
        chk("R9", "unbuffered write applies at once", 32'(mx), 6);

        idle(4);
        summary();
    end

endmodule